// File: doc/BRIEF.md
# Settable Hours-Minutes-Seconds Clock

This block keeps a 12-hour time of day in three binary counters (hours, minutes, seconds). It runs on a fast system clock. A one-cycle pulse arriving once per second advances the time when the block is in its running mode. Two front-panel keys, already debounced outside the block, control it. The mode key steps a four-state mode machine. The set key bumps the field that is currently selected for adjustment.

After reset the block sits in an initial state showing 12:00:00, and the time does not advance. Presses of the mode key walk through hour adjust, minute adjust and running. From running, the next press goes back to hour adjust, so the initial state is never entered again except by reset. Each key passes through a two-flop synchroniser and a rising-edge detector, so one press counts once however long the key is held. The current mode is reported on a 2-bit output.

Top module: `hms_clock`

## Requirements
- R1: While reset is high, and after it is released until the first key press, the mode output is 0 (init) and the time reads hours=12, minutes=0, seconds=0.
- R2: Each mode-key press moves the mode one step: init(0) to hour-adjust(1), hour-adjust(1) to minute-adjust(2), minute-adjust(2) to run(3), and run(3) back to hour-adjust(1). The mode never changes without a mode-key press.
- R3: In hour-adjust mode, each set-key press adds one to hours, with 12 wrapping to 1. Minutes and seconds do not change.
- R4: In minute-adjust mode, each set-key press adds one to minutes, with 59 wrapping to 0 and no carry into hours.
- R5: While the mode is minute-adjust, seconds read 0. Seconds are cleared on entry to this mode, and the second pulse leaves them at 0.
- R6: In run mode, each second pulse adds one to seconds. With no pulse, none of the three fields changes.
- R7: In run mode, a second pulse at seconds=59 sets seconds to 0 and adds one to minutes.
- R8: In run mode, a second pulse at minutes=59 and seconds=59 clears both and adds one to hours. 12:59:59 becomes 1:00:00.
- R9: The second pulse has no effect in init and hour-adjust modes. The set key has no effect in init and run modes.
- R10: A key held high for many clock cycles counts as exactly one press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| mode_key | input | 1 | Debounced mode key, level |
| set_key | input | 1 | Debounced set key, level |
| hours | output | 4 | Hour count, 1..12 |
| minutes | output | 6 | Minute count, 0..59 |
| seconds | output | 6 | Second count, 0..59 |
| mode | output | 2 | 0 init, 1 hour adjust, 2 minute adjust, 3 run |

## Verification
Some properties are checked on every cycle:
- the mode moves only in a cycle that carries a mode-key event;
- the init state is never re-entered;
- the fields stay inside their ranges;
- seconds are zero after any minute-adjust cycle;
- the fields hold in cycles without an increment cause;
- each detected key event lasts a single cycle.

The bench scenarios cover what needs a long sequence of stimulus and a known expected time:
- the full mode cycle;
- wrap points reached through many set presses;
- carry chains up to 12:59:59 rolling to 1:00:00;
- a key held high for many cycles giving a single step.

// File: rtl/hms_pkg.sv
package hms_pkg;

  typedef enum logic [1:0] {
    MODE_INIT = 2'd0,
    MODE_HOUR = 2'd1,
    MODE_MIN  = 2'd2,
    MODE_RUN  = 2'd3
  } clk_mode_e;

  // Fixed mode cycle; init is left once and never re-entered.
  function automatic clk_mode_e next_mode(input clk_mode_e cur);
    case (cur)
      MODE_INIT: next_mode = MODE_HOUR;
      MODE_HOUR: next_mode = MODE_MIN;
      MODE_MIN:  next_mode = MODE_RUN;
      default:   next_mode = MODE_HOUR;
    endcase
  endfunction

endpackage

// File: rtl/key_edge.sv
module key_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic key_in,
  output logic press_evt
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= key_in;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign press_evt = sync_q[STAGES-1] & ~last_q;

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
    press_evt |=> !press_evt); // R10

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import hms_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step_evt,
  output clk_mode_e mode_q
);

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= MODE_INIT;
    else if (step_evt) mode_q <= next_mode(mode_q);
  end

  AST_MODE_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (rst)
    !step_evt |=> $stable(mode_q)); // R2

  AST_NO_INIT_RETURN: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_INIT) |=> (mode_q != MODE_INIT)); // R2

endmodule

// File: rtl/wrap_ctr.sv
module wrap_ctr #(
  parameter int W      = 6,
  parameter int LO     = 0,
  parameter int HI     = 59,
  parameter int RSTVAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_hi
);

  localparam logic [W-1:0] LO_V  = W'(LO);
  localparam logic [W-1:0] HI_V  = W'(HI);
  localparam logic [W-1:0] RST_V = W'(RSTVAL);

  function automatic logic [W-1:0] step_val(input logic [W-1:0] v);
    step_val = (v == HI_V) ? LO_V : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_V;
    else if (clr) q <= LO_V;
    else if (inc) q <= step_val(q);
  end

  assign at_hi = (q == HI_V);

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (q >= LO_V) && (q <= HI_V)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(q)); // R6

endmodule

// File: rtl/hms_clock.sv
module hms_clock
  import hms_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HR_W        = 4,
  parameter int MS_W        = 6,
  parameter int HR_MAX      = 12,
  parameter int MS_MAX      = 59
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_1hz,
  input  logic            mode_key,
  input  logic            set_key,
  output logic [HR_W-1:0] hours,
  output logic [MS_W-1:0] minutes,
  output logic [MS_W-1:0] seconds,
  output logic [1:0]      mode
);

  logic      mode_evt, set_evt;
  clk_mode_e mode_q;
  logic      in_run, in_hr_adj, in_min_adj;
  logic      sec_top, min_top, hr_top;
  logic      sec_inc, min_inc, hr_inc;

  key_edge #(.STAGES(SYNC_STAGES)) u_mode_key (
    .clk(clk), .rst(rst), .key_in(mode_key), .press_evt(mode_evt));

  key_edge #(.STAGES(SYNC_STAGES)) u_set_key (
    .clk(clk), .rst(rst), .key_in(set_key), .press_evt(set_evt));

  mode_fsm u_fsm (
    .clk(clk), .rst(rst), .step_evt(mode_evt), .mode_q(mode_q));

  assign in_run     = (mode_q == MODE_RUN);
  assign in_hr_adj  = (mode_q == MODE_HOUR);
  assign in_min_adj = (mode_q == MODE_MIN);

  // Carry chain in run mode; manual bumps in adjust modes never carry.
  assign sec_inc = in_run & tick_1hz;
  assign min_inc = (sec_inc & sec_top) | (in_min_adj & set_evt);
  assign hr_inc  = (sec_inc & sec_top & min_top) | (in_hr_adj & set_evt);

  wrap_ctr #(.W(MS_W), .LO(0), .HI(MS_MAX), .RSTVAL(0)) u_sec (
    .clk(clk), .rst(rst), .clr(in_min_adj), .inc(sec_inc),
    .q(seconds), .at_hi(sec_top));

  wrap_ctr #(.W(MS_W), .LO(0), .HI(MS_MAX), .RSTVAL(0)) u_min (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(min_inc),
    .q(minutes), .at_hi(min_top));

  wrap_ctr #(.W(HR_W), .LO(1), .HI(HR_MAX), .RSTVAL(HR_MAX)) u_hr (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(hr_inc),
    .q(hours), .at_hi(hr_top));

  assign mode = mode_q;

  AST_RESET_TIME: assert property (@(posedge clk)
    $past(rst) |-> (hours == HR_W'(HR_MAX) && minutes == '0 && seconds == '0)); // R1

  AST_SEC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    in_min_adj |=> (seconds == '0)); // R5

  AST_HOUR_ADJ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    in_hr_adj |=> ($stable(minutes) && $stable(seconds))); // R3

  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hr_inc && hr_top) |=> (hours == HR_W'(1))); // R8

  AST_MIN_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_min_adj |=> $stable(hours)); // R4

  AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_INIT) |=> ($stable(hours) && $stable(minutes) && $stable(seconds))); // R9

endmodule

// File: tb/hms_clock_tb_top.sv
module hms_clock_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       mode_key = 1'b0;
  logic       set_key = 1'b0;
  logic [3:0] hours;
  logic [5:0] minutes, seconds;
  logic [1:0] mode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hms_clock dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .mode_key(mode_key),
    .set_key(set_key), .hours(hours), .minutes(minutes),
    .seconds(seconds), .mode(mode));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_time(input string tag, input int h, input int m, input int s);
    chk({tag, " hours"}, int'(hours), h);
    chk({tag, " minutes"}, int'(minutes), m);
    chk({tag, " seconds"}, int'(seconds), s);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic press_mode();
    @(negedge clk); mode_key = 1'b1;
    repeat (5) @(negedge clk); mode_key = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic press_set(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); set_key = 1'b1;
      repeat (5) @(negedge clk); set_key = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_and_init();
    @(negedge clk);
    chk("R1 mode in reset", int'(mode), 0);
    chk_time("R1 in reset", 12, 0, 0);
    do_reset();
    chk("R1 mode after reset", int'(mode), 0);
    chk_time("R1 after reset", 12, 0, 0);
    press_set(2);
    ticks(3);
    chk("R9 init mode kept", int'(mode), 0);
    chk_time("R9 init ignores set and tick", 12, 0, 0);
  endtask

  task automatic t_mode_cycle();
    do_reset();
    press_mode(); chk("R2 init->hour", int'(mode), 1);
    @(negedge clk); mode_key = 1'b1;
    repeat (40) @(negedge clk); mode_key = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 held key one step", int'(mode), 2);
    press_mode(); chk("R2 min->run", int'(mode), 3);
    press_mode(); chk("R2 run->hour", int'(mode), 1);
    repeat (20) @(negedge clk);
    chk("R2 no change without key", int'(mode), 1);
  endtask

  task automatic t_hour_adjust();
    do_reset();
    press_mode();
    press_set(1);
    chk_time("R3 12 wraps to 1", 1, 0, 0);
    press_set(10);
    chk_time("R3 ten presses", 11, 0, 0);
    ticks(4);
    chk_time("R9 tick ignored in hour adjust", 11, 0, 0);
    @(negedge clk); set_key = 1'b1;
    repeat (30) @(negedge clk); set_key = 1'b0;
    repeat (5) @(negedge clk);
    chk_time("R10 held set one increment", 12, 0, 0);
  endtask

  task automatic t_min_adjust();
    do_reset();
    press_mode(); press_mode();
    press_set(59);
    chk_time("R4 minutes to 59", 12, 59, 0);
    press_set(1);
    chk_time("R4 59 wraps no carry", 12, 0, 0);
  endtask

  task automatic t_sec_clear();
    do_reset();
    press_mode(); press_mode(); press_mode();
    ticks(5);
    chk_time("R6 five ticks", 12, 0, 5);
    press_mode();
    chk_time("R3 hour adjust keeps seconds", 12, 0, 5);
    press_mode();
    chk_time("R5 seconds cleared in minute adjust", 12, 0, 0);
    ticks(3);
    chk_time("R5 seconds stay zero", 12, 0, 0);
  endtask

  task automatic t_run();
    do_reset();
    press_mode(); press_mode(); press_mode();
    ticks(59);
    chk_time("R6 59 ticks", 12, 0, 59);
    ticks(1);
    chk_time("R7 seconds carry", 12, 1, 0);
    press_set(2);
    chk_time("R9 set ignored in run", 12, 1, 0);
    repeat (50) @(negedge clk);
    chk_time("R6 no tick no change", 12, 1, 0);
  endtask

  task automatic t_full_carry();
    do_reset();
    press_mode(); press_mode();
    press_set(59);
    press_mode();
    ticks(59);
    chk_time("R8 at 12:59:59", 12, 59, 59);
    ticks(1);
    chk_time("R8 rolls to 1:00:00", 1, 0, 0);
    press_mode(); press_set(10); press_mode(); press_set(59); press_mode();
    ticks(60);
    chk_time("R8 11:59:59 plus one", 12, 0, 0);
  endtask

  initial begin
    t_reset_and_init();
    t_mode_cycle();
    t_hour_adjust();
    t_min_adjust();
    t_sec_clear();
    t_run();
    t_full_carry();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule